// File: doc/BRIEF.md
# Serial Channel Host Register Interface

This block is the host-side register decode for a single asynchronous serial channel. A byte-wide host bus reaches four even byte offsets. Several of them mean one thing on read and another on write. The block turns host accesses into configuration fields and control strobes for the channel datapath. It also returns status and received characters to the host. The serial shifters and any interrupt logic sit outside this block.

Two small state machines hold the control state. The mode pointer machine has two states. In `PTR_FIRST`, an access to offset 0 reaches the first mode register, and the access itself moves the machine to `PTR_SECOND`. In `PTR_SECOND`, every later access to offset 0 reaches the second mode register, and the machine stays there. The pointer-reset command takes it back to `PTR_FIRST`. The receiver and the transmitter each have a direction machine with two states, `DIR_OFF` (the reset state) and `DIR_ON`. An enable field moves a direction from `DIR_OFF` to `DIR_ON`. A disable field moves it from `DIR_ON` to `DIR_OFF`. A reset command forces `DIR_OFF` and emits a one-cycle reset strobe. A reset command wins over an enable written in the same byte.

The offset map:

| Offset | Read | Write |
|---|---|---|
| 0 | mode register selected by the pointer | mode register selected by the pointer |
| 2 | status | clock select |
| 4 | reads 0 | command |
| 6 | receive queue head | transmit character |

Top module: `sercfg_regs`

## Requirements
- R1: After reset, rx_en, tx_en, rx_rst, tx_rst, tx_load and rxq_pop are 0. mode1, mode2 and clk_sel are 0, and the mode pointer is in `PTR_FIRST`.
- R2: In `PTR_FIRST`, a read or write at offset 0 accesses mode1 and moves the pointer to `PTR_SECOND`. In `PTR_SECOND`, every access at offset 0 targets mode2, and the pointer stays there.
- R3: A command write whose bits 6:4 equal 3'b001 (for example 0x10) returns the mode pointer to `PTR_FIRST`.
- R4: In a command byte, bits 1:0 control the receiver and bits 3:2 control the transmitter. In each field, 01 enables the direction, 10 disables it, and 00 or 11 leaves it unchanged. A command of 0x05 enables both directions.
- R5: When command bits 6:4 equal 3'b010 (for example 0x20), rx_rst is high for the one cycle after the write and rx_en becomes 0. When bits 6:4 equal 3'b011 (for example 0x30), the same happens with tx_rst and tx_en. The reset takes priority over an enable written in the same byte.
- R6: A read at offset 2 returns status. Bit 0 is receiver ready (rxq_valid AND rx_en). Bit 2 is transmitter ready (tx_ready AND tx_en). All other bits are 0.
- R7: A write at offset 2 loads clk_sel. A read at offset 2 returns status, not clk_sel.
- R8: A read at offset 6 returns rxq_data combinationally. In the same cycle it raises rxq_pop, but only when rxq_valid is 1. A read at any other offset never raises rxq_pop.
- R9: A write at offset 6 while transmitter ready (status bit 2) is 1 raises tx_load for the one following cycle, with tx_data holding the written byte. A write while transmitter ready is 0 is ignored: tx_load stays 0 and tx_data keeps its value.
- R10: char_len equals 5 plus mode1 bits 1:0. parity_en is 0 when mode1 bits 4:3 equal 2'b10, and 1 otherwise.
- R11: A read at offset 4 returns 0. An access at an odd offset reads 0 and changes no register, pointer or direction state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Host access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| rxq_valid | input | 1 | Receive queue holds a character |
| rxq_data | input | DATA_W | Head of the receive queue |
| rxq_pop | output | 1 | Consume the head of the receive queue |
| tx_ready | input | 1 | Transmit side can accept a character |
| tx_load | output | 1 | One-cycle strobe carrying a new transmit character |
| tx_data | output | DATA_W | Transmit character |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| rx_rst | output | 1 | One-cycle receiver reset strobe |
| tx_rst | output | 1 | One-cycle transmitter reset strobe |
| mode1 | output | DATA_W | First mode register |
| mode2 | output | DATA_W | Second mode register |
| clk_sel | output | DATA_W | Clock select register |
| char_len | output | 4 | Character length in bits (5 to 8) |
| parity_en | output | 1 | Parity generation and checking on |

## Verification
The mode address is driven in several sequences. One writes twice and then a third time, which shows whether the pointer sticks at mode2 or wraps around. One resets the pointer and reads back, which shows whether a read also advances the pointer. Command bytes are applied in turn: each single-direction enable, each disable, the 11 "no change" code, and a reset combined with an enable. Together these separate the two fields and show the priority of reset over enable. Reads and writes at the shared offsets are made with the queue full and empty and with transmit ready high and low, so that status, clock select, pop and load are each shown to follow only their own side of the address.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    typedef enum logic {
        PTR_FIRST  = 1'b0,
        PTR_SECOND = 1'b1
    } ptr_state_t;

    typedef enum logic {
        DIR_OFF = 1'b0,
        DIR_ON  = 1'b1
    } dir_state_t;

    typedef enum logic [2:0] {
        MISC_NONE   = 3'b000,
        MISC_PTRRST = 3'b001,
        MISC_RXRST  = 3'b010,
        MISC_TXRST  = 3'b011
    } misc_code_t;

    localparam int NUM_DIR = 2;
    localparam int DIR_RX  = 0;
    localparam int DIR_TX  = 1;

    typedef struct packed {
        logic [NUM_DIR-1:0] en_req;
        logic [NUM_DIR-1:0] dis_req;
        logic [NUM_DIR-1:0] rst_req;
        logic               ptr_rst;
    } cmd_act_t;

endpackage

// File: rtl/sercfg_cmd_decode.sv
module sercfg_cmd_decode
    import sercfg_pkg::*;
(
    input  logic       wr_stb,
    input  logic [6:0] cmd,
    output cmd_act_t   act
);
    logic [2:0] misc;

    always_comb begin
        misc = cmd[6:4];
        act  = '0;
        if (wr_stb) begin
            for (int d = 0; d < NUM_DIR; d++) begin
                act.en_req[d]  = (cmd[2*d +: 2] == 2'b01);
                act.dis_req[d] = (cmd[2*d +: 2] == 2'b10);
            end
            unique case (misc)
                MISC_PTRRST: act.ptr_rst         = 1'b1;
                MISC_RXRST:  act.rst_req[DIR_RX] = 1'b1;
                MISC_TXRST:  act.rst_req[DIR_TX] = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/sercfg_mode_ptr.sv
module sercfg_mode_ptr
    import sercfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic ptr_rst,
    output logic sel_second
);
    ptr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_FIRST:  if (access)  state_d = PTR_SECOND;
            PTR_SECOND: if (ptr_rst) state_d = PTR_FIRST;
            default:    state_d = PTR_FIRST;
        endcase
    end

    always_comb begin
        sel_second = (state_q == PTR_SECOND);
    end
endmodule

// File: rtl/sercfg_dir_ctrl.sv
module sercfg_dir_ctrl
    import sercfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    input  logic rst_req,
    output logic enabled,
    output logic rst_pulse
);
    dir_state_t state_q, state_d;
    logic       pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIR_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_OFF: if (en_req && !rst_req)      state_d = DIR_ON;
            DIR_ON:  if (rst_req || dis_req)      state_d = DIR_OFF;
            default: state_d = DIR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= rst_req;
    end

    always_comb begin
        enabled   = (state_q == DIR_ON);
        rst_pulse = pulse_q;
    end
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
    import sercfg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rxq_valid,
    input  logic [DATA_W-1:0] rxq_data,
    output logic              rxq_pop,
    input  logic              tx_ready,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              rx_en,
    output logic              tx_en,
    output logic              rx_rst,
    output logic              tx_rst,
    output logic [DATA_W-1:0] mode1,
    output logic [DATA_W-1:0] mode2,
    output logic [DATA_W-1:0] clk_sel,
    output logic [3:0]        char_len,
    output logic              parity_en
);
    localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(6);
    localparam logic [3:0]        LEN_BASE = 4'd5;
    localparam logic [1:0]        PAR_NONE = 2'b10;

    logic hit_mode, hit_stat, hit_cmd, hit_buf;
    logic wr_mode, wr_stat, wr_cmd, wr_buf, rd_buf;
    logic sel_second;
    logic tx_rdy_now, rx_rdy_now;
    logic [NUM_DIR-1:0] dir_on, dir_rst;
    logic [DATA_W-1:0]  status;
    cmd_act_t act;

    always_comb begin
        hit_mode = bus_sel && (bus_addr == OFS_MODE);
        hit_stat = bus_sel && (bus_addr == OFS_STAT);
        hit_cmd  = bus_sel && (bus_addr == OFS_CMD);
        hit_buf  = bus_sel && (bus_addr == OFS_BUF);
        wr_mode  = hit_mode && bus_wr;
        wr_stat  = hit_stat && bus_wr;
        wr_cmd   = hit_cmd  && bus_wr;
        wr_buf   = hit_buf  && bus_wr;
        rd_buf   = hit_buf  && !bus_wr;
    end

    sercfg_cmd_decode u_dec (
        .wr_stb (wr_cmd),
        .cmd    (bus_wdata[6:0]),
        .act    (act)
    );

    sercfg_mode_ptr u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .access     (hit_mode),
        .ptr_rst    (act.ptr_rst),
        .sel_second (sel_second)
    );

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        sercfg_dir_ctrl u_dir (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_req    (act.en_req[g]),
            .dis_req   (act.dis_req[g]),
            .rst_req   (act.rst_req[g]),
            .enabled   (dir_on[g]),
            .rst_pulse (dir_rst[g])
        );
    end

    always_comb begin
        rx_en  = dir_on[DIR_RX];
        tx_en  = dir_on[DIR_TX];
        rx_rst = dir_rst[DIR_RX];
        tx_rst = dir_rst[DIR_TX];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode1   <= '0;
            mode2   <= '0;
            clk_sel <= '0;
        end else begin
            if (wr_mode && !sel_second) mode1 <= bus_wdata;
            if (wr_mode &&  sel_second) mode2 <= bus_wdata;
            if (wr_stat)                clk_sel <= bus_wdata;
        end
    end

    always_comb begin
        tx_rdy_now = tx_ready && tx_en;
        rx_rdy_now = rxq_valid && rx_en;
        status     = '0;
        status[0]  = rx_rdy_now;
        status[2]  = tx_rdy_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_load <= 1'b0;
            tx_data <= '0;
        end else begin
            tx_load <= wr_buf && tx_rdy_now;
            if (wr_buf && tx_rdy_now) tx_data <= bus_wdata;
        end
    end

    always_comb begin
        rxq_pop   = rd_buf && rxq_valid;
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_mode)     bus_rdata = sel_second ? mode2 : mode1;
            else if (hit_stat) bus_rdata = status;
            else if (hit_buf)  bus_rdata = rxq_data;
        end
    end

    always_comb begin
        char_len  = LEN_BASE + {2'b00, mode1[1:0]};
        parity_en = (mode1[4:3] != PAR_NONE);
    end
endmodule

// File: rtl/sercfg_regs_chk.sv
module sercfg_regs_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rxq_valid,
    input logic              rxq_pop,
    input logic              tx_ready,
    input logic              tx_load,
    input logic              rx_en,
    input logic              tx_en,
    input logic              rx_rst,
    input logic              tx_rst,
    input logic [DATA_W-1:0] mode1
);
    assert_pop_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop |-> (rxq_valid && bus_sel && !bus_wr && bus_addr == ADDR_W'(6)));

    assert_load_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(tx_ready && tx_en && bus_sel && bus_wr));

    assert_rx_reset_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |-> !rx_en);

    assert_tx_reset_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |-> !tx_en);

    assert_rx_enable_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(4)));

    assert_status_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(2)) |->
        (bus_rdata[DATA_W-1:3] == '0 && bus_rdata[1] == 1'b0 &&
         bus_rdata[0] == (rxq_valid && rx_en) && bus_rdata[2] == (tx_ready && tx_en)));

    assert_mode1_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode1) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(0)));
endmodule

bind sercfg_regs sercfg_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .rxq_valid (rxq_valid),
    .rxq_pop   (rxq_pop),
    .tx_ready  (tx_ready),
    .tx_load   (tx_load),
    .rx_en     (rx_en),
    .tx_en     (tx_en),
    .rx_rst    (rx_rst),
    .tx_rst    (tx_rst),
    .mode1     (mode1)
);

// File: tb/sercfg_regs_tb_top.sv
`timescale 1ns/1ps
module sercfg_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       rxq_valid = 1'b0, rxq_pop, tx_ready = 1'b0, tx_load;
    logic [7:0] rxq_data = '0, tx_data, mode1, mode2, clk_sel;
    logic       rx_en, tx_en, rx_rst, tx_rst, parity_en;
    logic [3:0] char_len;
    int         total = 0, bad = 0;
    bit         done = 1'b0;
    logic [7:0] rd;
    logic       popped;

    always #2 clk = ~clk;

    sercfg_regs dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdb(input logic [2:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        rd = bus_rdata; popped = rxq_pop;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        chk(rx_en == 0 && tx_en == 0, "R1 enables", {rx_en, tx_en}, 0);
        chk(rx_rst == 0 && tx_rst == 0 && tx_load == 0 && rxq_pop == 0, "R1 strobes",
            {rx_rst, tx_rst, tx_load, rxq_pop}, 0);
        chk(mode1 == 0 && mode2 == 0 && clk_sel == 0, "R1 registers", {mode1, mode2, clk_sel}, 0);
    endtask

    task automatic t_mode_ptr();
        wr(3'd0, 8'h93);
        wr(3'd0, 8'h37);
        chk(mode1 == 8'h93, "R2 first write mode1", mode1, 8'h93);
        chk(mode2 == 8'h37, "R2 second write mode2", mode2, 8'h37);
        wr(3'd0, 8'h11);
        chk(mode2 == 8'h11 && mode1 == 8'h93, "R2 pointer sticks", {mode1, mode2}, 16'h9311);
        wr(3'd4, 8'h10);
        rdb(3'd0);
        chk(rd == 8'h93, "R3 pointer reset reads mode1", rd, 8'h93);
        rdb(3'd0);
        chk(rd == 8'h11, "R2 read advances pointer", rd, 8'h11);
    endtask

    task automatic t_format();
        chk(char_len == 4'd8 && parity_en == 0, "R10 0x93 format", {char_len, 3'b0, parity_en}, 8'h80);
        wr(3'd4, 8'h10);
        wr(3'd0, 8'h01);
        chk(char_len == 4'd6 && parity_en == 1, "R10 0x01 format", {char_len, 3'b0, parity_en}, 8'h61);
        chk(mode2 == 8'h11, "R3 mode2 kept", mode2, 8'h11);
    endtask

    task automatic t_enable();
        wr(3'd4, 8'h01);
        chk(rx_en == 1 && tx_en == 0, "R4 rx enable", {rx_en, tx_en}, 2'b10);
        wr(3'd4, 8'h04);
        chk(rx_en == 1 && tx_en == 1, "R4 tx enable", {rx_en, tx_en}, 2'b11);
        wr(3'd4, 8'h02);
        chk(rx_en == 0 && tx_en == 1, "R4 rx disable", {rx_en, tx_en}, 2'b01);
        wr(3'd4, 8'h0F);
        chk(rx_en == 0 && tx_en == 1, "R4 code 11 no change", {rx_en, tx_en}, 2'b01);
        wr(3'd4, 8'h08);
        chk(rx_en == 0 && tx_en == 0, "R4 tx disable", {rx_en, tx_en}, 2'b00);
        wr(3'd4, 8'h05);
        chk(rx_en == 1 && tx_en == 1, "R4 0x05 both", {rx_en, tx_en}, 2'b11);
    endtask

    task automatic t_reset_cmd();
        wr(3'd4, 8'h20);
        chk(rx_rst == 1 && tx_rst == 0, "R5 rx reset strobe", {rx_rst, tx_rst}, 2'b10);
        chk(rx_en == 0 && tx_en == 1, "R5 rx reset disables", {rx_en, tx_en}, 2'b01);
        @(negedge clk);
        chk(rx_rst == 0, "R5 strobe one cycle", rx_rst, 0);
        wr(3'd4, 8'h35);
        chk(tx_rst == 1 && tx_en == 0 && rx_en == 1, "R5 tx reset wins over enable",
            {tx_rst, tx_en, rx_en}, 3'b101);
        wr(3'd4, 8'h05);
    endtask

    task automatic t_status();
        rxq_valid = 1'b1; tx_ready = 1'b1;
        rdb(3'd2);
        chk(rd == 8'h05, "R6 both ready", rd, 8'h05);
        chk(popped == 0, "R8 no pop on status read", popped, 0);
        rxq_valid = 1'b0;
        rdb(3'd2);
        chk(rd == 8'h04, "R6 tx only", rd, 8'h04);
        wr(3'd2, 8'hBB);
        chk(clk_sel == 8'hBB, "R7 clock select written", clk_sel, 8'hBB);
        rdb(3'd2);
        chk(rd == 8'h04, "R7 read returns status", rd, 8'h04);
    endtask

    task automatic t_rx();
        rxq_valid = 1'b1; rxq_data = 8'h5A;
        rdb(3'd6);
        chk(rd == 8'h5A && popped == 1, "R8 read pops", {rd, 7'b0, popped}, 16'h5A01);
        rxq_valid = 1'b0;
        rdb(3'd6);
        chk(popped == 0, "R8 no pop when empty", popped, 0);
    endtask

    task automatic t_tx();
        tx_ready = 1'b1;
        wr(3'd6, 8'h41);
        chk(tx_load == 1 && tx_data == 8'h41, "R9 accepted", {tx_load, tx_data}, 9'h141);
        @(negedge clk);
        chk(tx_load == 0, "R9 load one cycle", tx_load, 0);
        tx_ready = 1'b0;
        wr(3'd6, 8'h42);
        chk(tx_load == 0 && tx_data == 8'h41, "R9 ignored when not ready", {tx_load, tx_data}, 9'h041);
        tx_ready = 1'b1;
        wr(3'd4, 8'h08);
        wr(3'd6, 8'h43);
        chk(tx_load == 0 && tx_data == 8'h41, "R9 ignored when disabled", {tx_load, tx_data}, 9'h041);
        wr(3'd4, 8'h04);
    endtask

    task automatic t_misc();
        rdb(3'd4);
        chk(rd == 8'h00, "R11 command reads zero", rd, 0);
        wr(3'd5, 8'h0A);
        chk(rx_en == 1 && tx_en == 1, "R11 odd offset no command", {rx_en, tx_en}, 2'b11);
        wr(3'd3, 8'h77);
        chk(clk_sel == 8'hBB, "R11 odd offset no clock select", clk_sel, 8'hBB);
        wr(3'd1, 8'hEE);
        chk(mode1 == 8'h01 && mode2 == 8'h11, "R11 odd offset no mode", {mode1, mode2}, 16'h0111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_ptr();
        t_format();
        t_enable();
        t_reset_cmd();
        t_status();
        t_rx();
        t_tx();
        t_misc();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule